// File: doc/BRIEF.md
# Low-Pin-Count Bus Cycle Start Decoder

This block is the front end of a flash-style peripheral that sits on a 4-bit multiplexed low-pin-count bus. On every bus clock it samples the active-low frame strobe and the four data lines. It finds the nibble that opens a cycle and sorts it into one of two families. The first family is a generic bus cycle, where a second nibble gives the transfer type and direction. The second is a firmware-hub memory transfer, where the opening nibble alone gives the direction. Every nibble that follows an accepted opening is passed to a downstream sequencer, one per clock, tagged with a valid strobe.

The block also owns the output enable of the data lines. The sequencer asks for the bus through a drive request, and the block grants that request only while an accepted cycle is in progress. Whenever the host signals frame, the grant is withdrawn on the very next clock, so a host abort or time-out always takes the peripheral off the bus. An opening nibble that is not recognised, or a generic cycle that does not target memory, leaves the block in a quiet standby with the lines tri-stated. A mode-select input held high parks the decoder entirely, so a different interface can use the pins.

Top module: `lbus_cycle_front`

## Requirements
- R1: While `rstN` is sampled low, and on the clock after it, `cycStart`, `nibValid` and `ladOe` are 0.
- R2: When the last nibble seen with `frameN` low is 4'b1101 and `frameN` is then sampled high, the next clock shows `cycStart`=1 with `cycKind`=2'b10 (firmware-hub read), `nibValid`=1 and `nibble` equal to the data sampled on that first high-frame clock.
- R3: Opening nibble 4'b1110 behaves as in R2 but gives `cycKind`=2'b11 (firmware-hub write).
- R4: Opening nibble 4'b0000, followed by a type nibble whose bits [3:2] are 2'b01, gives `cycStart`=1 on the next clock with `cycKind`=2'b01 if type bit [1] is 1 (write) or 2'b00 if it is 0 (read). The type nibble itself is not reported (`nibValid`=0 on that clock).
- R5: Opening nibble 4'b0000 with a type nibble whose bits [3:2] are not 2'b01 raises no `cycStart`, no `nibValid` and no `ladOe` until frame is asserted again.
- R6: An opening nibble other than 4'b0000, 4'b1101 or 4'b1110 raises no `cycStart`, no `nibValid` and no `ladOe` until frame is asserted again.
- R7: When `frameN` stays low for several clocks, only the nibble on its last low clock is decoded as the opening nibble.
- R8: After an accepted cycle begins, each clock with `frameN` high yields `nibValid`=1 on the following clock with `nibble` equal to the data sampled then.
- R9: Whenever `frameN` is sampled low, the following clock shows `ladOe`=0 and `nibValid`=0, whatever the block was doing.
- R10: While `muxSel` is high, the following clock shows `cycStart`, `nibValid` and `ladOe` at 0, whatever the frame and data lines do.
- R11: `ladOe` is 1 on a clock only if, on the previous clock, an accepted cycle was in its nibble stream, `frameN` was high and `drvReq` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| muxSel | input | 1 | High parks the decoder; low enables the bus interface |
| frameN | input | 1 | Frame strobe from the host, active low |
| ladIn | input | 4 | Sampled value of the data lines |
| drvReq | input | 1 | Sequencer asks to drive the data lines |
| cycStart | output | 1 | One-clock pulse when a cycle is accepted |
| cycKind | output | 2 | 00 generic read, 01 generic write, 10 hub read, 11 hub write |
| nibValid | output | 1 | `nibble` carries a field nibble of the current cycle |
| nibble | output | 4 | Field nibble passed to the sequencer |
| ladOe | output | 1 | Output enable for the data lines |

## Verification
Every one of the 16 opening nibbles is paired with every one of the 16 following nibbles, so the bench can tell the three accepted codes from the thirteen rejected ones. For the generic family it can also tell the memory type, read or write, from the other transfer types. Frame is held low for one clock on some passes and for two on others, with a wrong nibble on the earlier clock, which shows that only the last low nibble counts. The drive request alternates across passes, and every pass ends with a new frame assertion, which exercises the grant and its withdrawal. A run with mode select high repeats an accepted sequence to show that the decoder stays silent.

// File: rtl/lbus_front_pkg.sv
package lbus_front_pkg;

  localparam int NIB_W  = 4;
  localparam int KIND_W = 2;

  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t CODE_GEN    = 4'b0000;
  localparam nib_t CODE_HUB_RD = 4'b1101;
  localparam nib_t CODE_HUB_WR = 4'b1110;
  localparam logic [1:0] TYPE_MEM = 2'b01;

  typedef enum logic [KIND_W-1:0] {
    KIND_GEN_RD = 2'b00,
    KIND_GEN_WR = 2'b01,
    KIND_HUB_RD = 2'b10,
    KIND_HUB_WR = 2'b11
  } cycKind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_HOLD   = 2'b01,
    ST_STREAM = 2'b10
  } frontState_e;

  typedef struct packed {
    logic     startPulse;
    cycKind_e kind;
    logic     nibStrobe;
    logic     oeNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/lbus_front_ctrl.sv
module lbus_front_ctrl
  import lbus_front_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         muxSel,
  input  logic         frameN,
  input  nib_t         ladIn,
  input  logic         drvReq,
  output ctrlStrobes_t strb
);

  frontState_e stateQ, stateD;
  nib_t        openQ, openD;

  always_comb begin
    stateD = stateQ;
    openD  = openQ;
    strb   = '0;
    if (muxSel) begin
      stateD = ST_IDLE;
    end else if (!frameN) begin
      // latest low-frame nibble overwrites earlier ones
      stateD = ST_HOLD;
      openD  = ladIn;
    end else begin
      case (stateQ)
        ST_HOLD: begin
          stateD = ST_IDLE;
          if (openQ == CODE_GEN) begin
            if (ladIn[3:2] == TYPE_MEM) begin
              stateD          = ST_STREAM;
              strb.startPulse = 1'b1;
              strb.kind       = ladIn[1] ? KIND_GEN_WR : KIND_GEN_RD;
            end
          end else if (openQ == CODE_HUB_RD) begin
            stateD          = ST_STREAM;
            strb.startPulse = 1'b1;
            strb.kind       = KIND_HUB_RD;
            strb.nibStrobe  = 1'b1;
          end else if (openQ == CODE_HUB_WR) begin
            stateD          = ST_STREAM;
            strb.startPulse = 1'b1;
            strb.kind       = KIND_HUB_WR;
            strb.nibStrobe  = 1'b1;
          end
        end
        ST_STREAM: begin
          strb.nibStrobe = 1'b1;
          strb.oeNext    = drvReq;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      openQ  <= '0;
    end else begin
      stateQ <= stateD;
      openQ  <= openD;
    end
  end

  AST_FRAME_TO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!muxSel && !frameN) |=> (stateQ == ST_HOLD)); // R7

  AST_MUX_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    muxSel |=> (stateQ == ST_IDLE)); // R10

endmodule

// File: rtl/lbus_front_dp.sv
module lbus_front_dp
  import lbus_front_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameN,
  input  logic               muxSel,
  input  logic               drvReq,
  input  nib_t               ladIn,
  input  ctrlStrobes_t       strb,
  output logic               cycStart,
  output logic [KIND_W-1:0]  cycKind,
  output logic               nibValid,
  output nib_t               nibble,
  output logic               ladOe
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycStart <= 1'b0;
      cycKind  <= KIND_GEN_RD;
      nibValid <= 1'b0;
      nibble   <= '0;
      ladOe    <= 1'b0;
    end else begin
      cycStart <= strb.startPulse;
      nibValid <= strb.nibStrobe;
      ladOe    <= strb.oeNext;
      if (strb.startPulse) cycKind <= strb.kind;
      if (strb.nibStrobe)  nibble  <= ladIn;
    end
  end

  AST_OE_DROP_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (!ladOe && !nibValid)); // R9

  AST_MUX_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    muxSel |=> (!ladOe && !nibValid && !cycStart)); // R10

  AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ladOe |-> $past(drvReq)); // R11

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycStart |=> !cycStart); // R2

  AST_HUB_FIRST_NIB: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && cycKind[1]) |-> nibValid); // R3

  AST_GEN_TYPE_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && !cycKind[1]) |-> !nibValid); // R4

  AST_NIB_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    nibValid |-> $past(frameN)); // R8

endmodule

// File: rtl/lbus_cycle_front.sv
module lbus_cycle_front
  import lbus_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              muxSel,
  input  logic              frameN,
  input  logic [NIB_W-1:0]  ladIn,
  input  logic              drvReq,
  output logic              cycStart,
  output logic [KIND_W-1:0] cycKind,
  output logic              nibValid,
  output logic [NIB_W-1:0]  nibble,
  output logic              ladOe
);

  ctrlStrobes_t strb;

  lbus_front_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .muxSel (muxSel),
    .frameN (frameN),
    .ladIn  (ladIn),
    .drvReq (drvReq),
    .strb   (strb)
  );

  lbus_front_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .muxSel   (muxSel),
    .drvReq   (drvReq),
    .ladIn    (ladIn),
    .strb     (strb),
    .cycStart (cycStart),
    .cycKind  (cycKind),
    .nibValid (nibValid),
    .nibble   (nibble),
    .ladOe    (ladOe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!cycStart && !nibValid && !ladOe)); // R1

endmodule

// File: tb/lbus_cycle_front_tb_top.sv
`timescale 1ns/1ps
module lbus_cycle_front_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       muxSel;
  logic       frameN;
  logic [3:0] ladIn;
  logic       drvReq;
  logic       cycStart;
  logic [1:0] cycKind;
  logic       nibValid;
  logic [3:0] nibble;
  logic       ladOe;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lbus_cycle_front dut_i (
    .clk(clk), .rstN(rstN), .muxSel(muxSel), .frameN(frameN),
    .ladIn(ladIn), .drvReq(drvReq), .cycStart(cycStart), .cycKind(cycKind),
    .nibValid(nibValid), .nibble(nibble), .ladOe(ladOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic [3:0] d);
    frameN = f;
    ladIn  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; muxSel = 1'b0; frameN = 1'b1; ladIn = 4'h0; drvReq = 1'b1;
    #1;
    step(1'b0, 4'hD);
    step(1'b1, 4'h3);
    chk("R1 cycStart", cycStart, 0);
    chk("R1 nibValid", nibValid, 0);
    chk("R1 ladOe", ladOe, 0);
    rstN = 1'b1;
    step(1'b1, 4'h0);
    chk("R1 idle cycStart", cycStart, 0);
    chk("R1 idle ladOe", ladOe, 0);

    // full sweep of opening nibble x following nibble
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        int  it, len;
        bit  drv, hub, gen, valid;
        int  kind;
        string tag;
        it    = s * 16 + f;
        len   = 1 + (it % 2);
        drv   = ((it / 4) % 2) == 1;
        hub   = (s == 13) || (s == 14);
        gen   = (s == 0) && ((f / 4) == 1);
        valid = hub || gen;
        kind  = (s == 13) ? 2 : (s == 14) ? 3 : ((f / 2) % 2);
        if (s == 13) tag = "R2";
        else if (s == 14) tag = "R3";
        else if (gen) tag = "R4";
        else if (s == 0) tag = "R5";
        else tag = "R6";
        drvReq = drv;
        for (int k = 0; k < len; k++) begin
          step(1'b0, (k == len - 1) ? 4'(s) : 4'(~s));
          if (k == 0) begin
            chk("R9 ladOe after frame", ladOe, 0);
            chk("R9 nibValid after frame", nibValid, 0);
          end
        end
        step(1'b1, 4'(f));
        chk({tag, " cycStart"}, cycStart, valid);
        if (len == 2) chk("R7 last low nibble decoded", cycStart, valid);
        if (valid) chk({tag, " cycKind"}, cycKind, kind);
        chk({tag, " first nibValid"}, nibValid, hub);
        if (hub) chk({tag, " first nibble"}, nibble, f);
        chk({tag, " ladOe at start"}, ladOe, 0);
        step(1'b1, 4'(f ^ 5));
        chk({tag, " R8 stream nibValid"}, nibValid, valid);
        if (valid) chk("R8 stream nibble", nibble, f ^ 5);
        chk("R11 ladOe grant", ladOe, valid && drv);
        chk({tag, " no second start"}, cycStart, 0);
      end
    end

    // mode select parks the decoder
    drvReq = 1'b1;
    step(1'b0, 4'hD);
    muxSel = 1'b1;
    step(1'b0, 4'hD);
    step(1'b1, 4'h7);
    chk("R10 cycStart", cycStart, 0);
    chk("R10 nibValid", nibValid, 0);
    step(1'b1, 4'h2);
    chk("R10 ladOe", ladOe, 0);
    chk("R10 nibValid stream", nibValid, 0);
    muxSel = 1'b0;
    step(1'b0, 4'hE);
    step(1'b1, 4'h9);
    chk("R3 after mux release", cycStart, 1);
    chk("R3 kind after mux release", cycKind, 3);
    step(1'b0, 4'h0);
    chk("R9 final drop", ladOe, 0);
    finish_run();
  end

endmodule